// File: doc/BRIEF.md
# Shared Mailbox Bank with Interrupt Aggregation

This block gives several processors a small bank of one-word mailboxes and a set of level-sensitive interrupt lines that report on them. A producer posts a message by writing a word with the top bit set. That bit is the FULL flag, and it lives inside the stored word. The consumer reads the word and then writes zero, which empties the mailbox again. Every mailbox is always either full or empty. Both conditions are gathered into one shared, read-only status word: the EMPTY flags sit in the low byte and the FULL flags in the byte above it.

Each interrupt output has its own 16-bit enable mask over that status word. The output stays high for as long as any enabled condition holds. As an option, each mailbox also has a local FULL enable and a local EMPTY enable, which gate its contribution to every output. A read-only sizing word reports how many resources of each kind the instance has. All access goes through a simple word bus: address, write enable, write data, and combinational read data.

Top module: `shmbox_irq_agg`

## Requirements
- R1: A write to offset 0x0 of mailbox window k stores all 32 bits as written, and they read back unchanged. Window k spans byte addresses (k+1)*0x1000 to (k+1)*0x1000+0xFFF. Bit 31 of the stored word is the FULL flag, so a stored word with bit 31 set makes mailbox k full.
- R2: Writing zero to a mailbox data word clears the whole word and makes that mailbox empty. A stored word with bit 31 clear is also empty.
- R3: The status word at 0x304 holds EMPTY of mailbox k in bit k and FULL of mailbox k in bit 8+k. Bits for mailboxes that are not present, and bits 31:16, read zero. Writes to 0x304 are ignored.
- R4: Interrupt output x has a 16-bit enable register at 0x100+4*x. Bits 15:0 read back as written, and bits 31:16 read zero.
- R5: Interrupt output x is high exactly when some status bit in 15:0 is set, is enabled in register x, and is passed by its local gate. The output is a level: it stays high for as long as that holds.
- R6: Offset 0x4 of a mailbox window is its local FULL enable and offset 0x8 is its local EMPTY enable, each held in bit 0 with the upper bits reading zero. A cleared local enable keeps that mailbox's condition off every interrupt output, but it does not change the status word.
- R7: The read-only sizing word at 0x380 reports the mailbox count in bits 3:0, shared semaphores in 7:4, arbitrated semaphores in 11:8, doorbells in 15:12 and interrupt outputs in 19:16. The default instance reads 0x00045248.
- R8: Reads of any unmapped or misaligned address return zero, and writes to such an address change no state. An address is misaligned when bits 1:0 are not zero.
- R9: After reset every mailbox word, every enable register and every local enable is zero. The status word therefore reads 0x000000FF and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | NUM_SHIRQ | Level-sensitive interrupt lines |

## Verification
On every cycle the assertions check the effect of a mailbox write on the status word, the rule that each mailbox is either full or empty, the zero upper half of the status word, that a write to the status word is ignored, and that the interrupt lines hold steady while no write arrives. Only the bench's scenarios can show the full read-back map, the per-output masking combined with the local gates, the sizing word, and that writes to unmapped or misaligned addresses leave every register untouched. The bench shows these by comparing each read and each interrupt line against a model of the register file.

// File: rtl/shmbox_pkg.sv
package shmbox_pkg;

  localparam int MAX_MBOX  = 8;
  localparam int MAX_SHIRQ = 15;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_DATA,
    RSEL_FIE,
    RSEL_EIE,
    RSEL_IEN,
    RSEL_STAT,
    RSEL_DIM
  } rsel_e;

  // Strobes from address decode to the register datapath
  typedef struct packed {
    logic [MAX_MBOX-1:0]  dataWe;
    logic [MAX_MBOX-1:0]  fieWe;
    logic [MAX_MBOX-1:0]  eieWe;
    logic [MAX_SHIRQ-1:0] ienWe;
    rsel_e                rdSel;
    logic [3:0]           rdIdx;
  } strobes_t;

endpackage

// File: rtl/shmbox_decode.sv
module shmbox_decode
  import shmbox_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int WIN_BITS     = 12,
  parameter int NUM_MBOX     = 8,
  parameter int NUM_SHIRQ    = 4,
  parameter bit HAS_LOCAL_IE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output strobes_t          stb
);

  localparam int WSEL_W   = ADDR_W - WIN_BITS;
  localparam int IEN_BASE = 'h100;
  localparam int STAT_OFF = 'h304;
  localparam int DIM_OFF  = 'h380;
  localparam int DATA_OFF = 'h0;
  localparam int FIE_OFF  = 'h4;
  localparam int EIE_OFF  = 'h8;

  logic [WSEL_W-1:0]   winSel;
  logic [WIN_BITS-1:0] winOff;
  logic                aligned;

  assign winSel  = addr[ADDR_W-1:WIN_BITS];
  assign winOff  = addr[WIN_BITS-1:0];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    stb       = '0;
    stb.rdSel = RSEL_NONE;
    if (aligned) begin
      if (winSel == '0) begin
        if (winOff == WIN_BITS'(STAT_OFF)) begin
          stb.rdSel = RSEL_STAT;
        end else if (winOff == WIN_BITS'(DIM_OFF)) begin
          stb.rdSel = RSEL_DIM;
        end else begin
          for (int x = 0; x < NUM_SHIRQ; x++) begin
            if (winOff == WIN_BITS'(IEN_BASE + 4 * x)) begin
              stb.rdSel    = RSEL_IEN;
              stb.rdIdx    = 4'(x);
              stb.ienWe[x] = we;
            end
          end
        end
      end else begin
        for (int k = 0; k < NUM_MBOX; k++) begin
          if (winSel == WSEL_W'(k + 1)) begin
            if (winOff == WIN_BITS'(DATA_OFF)) begin
              stb.rdSel     = RSEL_DATA;
              stb.rdIdx     = 4'(k);
              stb.dataWe[k] = we;
            end else if (HAS_LOCAL_IE && winOff == WIN_BITS'(FIE_OFF)) begin
              stb.rdSel    = RSEL_FIE;
              stb.rdIdx    = 4'(k);
              stb.fieWe[k] = we;
            end else if (HAS_LOCAL_IE && winOff == WIN_BITS'(EIE_OFF)) begin
              stb.rdSel    = RSEL_EIE;
              stb.rdIdx    = 4'(k);
              stb.eieWe[k] = we;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/shmbox_regs.sv
module shmbox_regs
  import shmbox_pkg::*;
#(
  parameter int          NUM_MBOX     = 8,
  parameter int          NUM_SHIRQ    = 4,
  parameter bit          HAS_LOCAL_IE = 1'b1,
  parameter logic [31:0] DIM_VALUE    = 32'h0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [31:0]          statusWord,
  output logic [NUM_SHIRQ-1:0] irqLines
);

  localparam int FULL_BASE = 8;
  localparam int COND_W    = 16;

  logic [31:0]       mbxWord [NUM_MBOX];
  logic [COND_W-1:0] ienMask [NUM_SHIRQ];
  logic [NUM_MBOX-1:0] fullVec;
  logic [NUM_MBOX-1:0] fieBits;
  logic [NUM_MBOX-1:0] eieBits;
  logic [COND_W-1:0]   gateMask;

  // Mailbox words: FULL flag is bit 31 of the stored word
  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbx
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mbxWord[m] <= '0;
      end else if (stb.dataWe[m]) begin
        mbxWord[m] <= wdata;
      end
    end
    assign fullVec[m] = mbxWord[m][31];
  end

  // Optional per-mailbox local enables
  if (HAS_LOCAL_IE) begin : g_lie
    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rstN) begin
          fieBits[m] <= 1'b0;
          eieBits[m] <= 1'b0;
        end else begin
          if (stb.fieWe[m]) fieBits[m] <= wdata[0];
          if (stb.eieWe[m]) eieBits[m] <= wdata[0];
        end
      end
    end
  end else begin : g_nolie
    assign fieBits = '0;
    assign eieBits = '0;
  end

  // Per-output enable masks
  for (genvar x = 0; x < NUM_SHIRQ; x++) begin : g_ien
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ienMask[x] <= '0;
      end else if (stb.ienWe[x]) begin
        ienMask[x] <= wdata[COND_W-1:0];
      end
    end
  end

  // Shared status word and local gate
  always_comb begin
    statusWord = '0;
    gateMask   = HAS_LOCAL_IE ? '0 : '1;
    for (int m = 0; m < NUM_MBOX; m++) begin
      statusWord[m]             = ~fullVec[m];
      statusWord[FULL_BASE + m] = fullVec[m];
      if (HAS_LOCAL_IE) begin
        gateMask[m]             = eieBits[m];
        gateMask[FULL_BASE + m] = fieBits[m];
      end
    end
  end

  // Level interrupt lines
  for (genvar x = 0; x < NUM_SHIRQ; x++) begin : g_irq
    assign irqLines[x] = |(statusWord[COND_W-1:0] & ienMask[x] & gateMask);
  end

  // Read mux
  always_comb begin
    rdata = '0;
    unique case (stb.rdSel)
      RSEL_DATA: begin
        for (int m = 0; m < NUM_MBOX; m++)
          if (stb.rdIdx == 4'(m)) rdata = mbxWord[m];
      end
      RSEL_FIE: begin
        for (int m = 0; m < NUM_MBOX; m++)
          if (stb.rdIdx == 4'(m)) rdata = {31'b0, fieBits[m]};
      end
      RSEL_EIE: begin
        for (int m = 0; m < NUM_MBOX; m++)
          if (stb.rdIdx == 4'(m)) rdata = {31'b0, eieBits[m]};
      end
      RSEL_IEN: begin
        for (int x = 0; x < NUM_SHIRQ; x++)
          if (stb.rdIdx == 4'(x)) rdata = {16'b0, ienMask[x]};
      end
      RSEL_STAT: rdata = statusWord;
      RSEL_DIM:  rdata = DIM_VALUE;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/shmbox_irq_agg.sv
module shmbox_irq_agg
  import shmbox_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int WIN_BITS     = 12,
  parameter int NUM_MBOX     = 8,
  parameter int NUM_SHIRQ    = 4,
  parameter int NUM_SSEM     = 4,
  parameter int NUM_ASEM     = 2,
  parameter int NUM_DB       = 5,
  parameter bit HAS_LOCAL_IE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_SHIRQ-1:0] irqOut
);

  localparam logic [31:0] DIM_VALUE = {12'b0, 4'(NUM_SHIRQ), 4'(NUM_DB),
                                       4'(NUM_ASEM), 4'(NUM_SSEM), 4'(NUM_MBOX)};

  strobes_t    stb;
  logic [31:0] statusWord;

  shmbox_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NUM_MBOX(NUM_MBOX),
    .NUM_SHIRQ(NUM_SHIRQ), .HAS_LOCAL_IE(HAS_LOCAL_IE)
  ) u_decode (
    .addr(busAddr),
    .we  (busWe),
    .stb (stb)
  );

  shmbox_regs #(
    .NUM_MBOX(NUM_MBOX), .NUM_SHIRQ(NUM_SHIRQ),
    .HAS_LOCAL_IE(HAS_LOCAL_IE), .DIM_VALUE(DIM_VALUE)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (busWdata),
    .rdata     (busRdata),
    .statusWord(statusWord),
    .irqLines  (irqOut)
  );

endmodule

// File: rtl/shmbox_checker.sv
module shmbox_checker #(
  parameter int ADDR_W    = 16,
  parameter int WIN_BITS  = 12,
  parameter int NUM_MBOX  = 8,
  parameter int NUM_SHIRQ = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWe,
  input logic [31:0]          busWdata,
  input logic [NUM_SHIRQ-1:0] irqOut,
  input logic [31:0]          statusWord
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h304);

  for (genvar k = 0; k < NUM_MBOX; k++) begin : g_k
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'((k + 1) << WIN_BITS);

    // R1
    full_on_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == DATA_ADDR && busWdata[31]) |=> (statusWord[8+k] && !statusWord[k]));

    // R2
    empty_on_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == DATA_ADDR && busWdata == 32'h0) |=> (statusWord[k] && !statusWord[8+k]));

    // R3
    one_state_chk: assert property (@(posedge clk) disable iff (!rstN)
      statusWord[k] != statusWord[8+k]);
  end

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:16] == 16'h0);

  // R3
  status_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == STAT_ADDR) |=> $stable(statusWord));

  // R5
  irq_level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWe) |-> $stable(irqOut));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (irqOut == '0));

endmodule

bind shmbox_irq_agg shmbox_checker #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NUM_MBOX(NUM_MBOX), .NUM_SHIRQ(NUM_SHIRQ)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busWdata  (busWdata),
  .irqOut    (irqOut),
  .statusWord(statusWord)
);

// File: tb/tb_shmbox_irq_agg.sv
module tb_shmbox_irq_agg;

  localparam int NM  = 8;
  localparam int NSI = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NSI-1:0] irqOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] mMbx [NM];
  logic [15:0] mIen [NSI];
  logic [NM-1:0] mFie;
  logic [NM-1:0] mEie;

  always #4 clk = ~clk;

  shmbox_irq_agg dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [31:0] mStatus();
    logic [31:0] s = '0;
    for (int k = 0; k < NM; k++) begin
      s[k]     = ~mMbx[k][31];
      s[8 + k] = mMbx[k][31];
    end
    return s;
  endfunction

  function automatic logic [NSI-1:0] mIrq();
    logic [NSI-1:0] v = '0;
    logic [31:0] s = mStatus();
    for (int x = 0; x < NSI; x++)
      for (int k = 0; k < NM; k++)
        if ((s[k] && mIen[x][k] && mEie[k]) || (s[8+k] && mIen[x][8+k] && mFie[k]))
          v[x] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] mRead(logic [15:0] a);
    int win = int'(a[15:12]);
    int off = int'(a[11:0]);
    if (a[1:0] != 2'b00) return '0;
    if (win == 0) begin
      if (off == 'h304) return mStatus();
      if (off == 'h380) return 32'h0004_5248;
      for (int x = 0; x < NSI; x++)
        if (off == 'h100 + 4 * x) return {16'h0, mIen[x]};
      return '0;
    end
    if (win >= 1 && win <= NM) begin
      if (off == 0) return mMbx[win-1];
      if (off == 4) return {31'h0, mFie[win-1]};
      if (off == 8) return {31'h0, mEie[win-1]};
    end
    return '0;
  endfunction

  task automatic mWrite(logic [15:0] a, logic [31:0] d);
    int win = int'(a[15:12]);
    int off = int'(a[11:0]);
    if (a[1:0] != 2'b00) return;
    if (win == 0) begin
      for (int x = 0; x < NSI; x++)
        if (off == 'h100 + 4 * x) mIen[x] = d[15:0];
    end else if (win <= NM) begin
      if (off == 0) mMbx[win-1] = d;
      else if (off == 4) mFie[win-1] = d[0];
      else if (off == 8) mEie[win-1] = d[0];
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    mWrite(a, d);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(string req, logic [15:0] a);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #2;
    chk(req, busRdata, mRead(a));
  endtask

  task automatic irqChk(string req);
    @(negedge clk);
    #1;
    chk(req, 32'(irqOut), 32'(mIrq()));
  endtask

  function automatic logic [15:0] randAddr();
    case ($urandom % 8)
      0, 1, 2: return 16'(((($urandom % 9) + 1) << 12) | (($urandom % 4) * 4));
      3:       return 16'('h100 + ($urandom % 6) * 4);
      4:       return 16'h0304;
      5:       return 16'h0380;
      6:       return 16'(16'h1000 * (($urandom % 8) + 1) + 16'h0002);
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [31:0] randData();
    case ($urandom % 5)
      0:       return 32'h0;
      1:       return {1'b1, 31'($urandom)};
      2:       return 32'($urandom % 2);
      default: return $urandom;
    endcase
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NM; k++) mMbx[k] = '0;
    for (int x = 0; x < NSI; x++) mIen[x] = '0;
    mFie = '0;
    mEie = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    rdChk("R9 status after reset", 16'h0304);
    chk("R9 status literal", busRdata, 32'h0000_00FF);
    irqChk("R9 irq after reset");
    rdChk("R9 mailbox0 after reset", 16'h1000);
    rdChk("R9 enable0 after reset", 16'h0100);

    // R7 sizing word
    rdChk("R7 dimensioning", 16'h0380);
    chk("R7 literal", busRdata, 32'h0004_5248);

    // R1 post message to mailbox 3
    wr(16'h4000, 32'h8000_1234);
    rdChk("R1 readback", 16'h4000);
    chk("R1 literal", busRdata, 32'h8000_1234);
    rdChk("R3 status full bit", 16'h0304);
    chk("R3 status literal", busRdata, 32'h0000_08F7);

    // R6 gate closed: enable full bit 11 on output 1 only
    wr(16'h0104, 32'h0000_0800);
    irqChk("R6 gate closed keeps irq low");
    chk("R6 irq1 low", 32'(irqOut[1]), 32'h0);
    wr(16'h4004, 32'h1);
    irqChk("R5 irq1 high when enabled");
    chk("R5 irq1 literal", 32'(irqOut), 32'h2);
    repeat (5) @(posedge clk);
    irqChk("R5 irq level holds");

    // R2 consumer clears
    wr(16'h4000, 32'h0);
    rdChk("R2 cleared word", 16'h4000);
    irqChk("R2 irq drops on empty");
    wr(16'h0108, 32'h0000_0008);
    wr(16'h4008, 32'h1);
    irqChk("R5 empty irq on output 2");
    chk("R5 irq2 literal", 32'(irqOut), 32'h4);
    wr(16'h4000, 32'h0000_0055);
    irqChk("R2 payload without flag stays empty");

    // R3 status is read-only
    wr(16'h0304, 32'hFFFF_FFFF);
    rdChk("R3 status write ignored", 16'h0304);

    // R4 upper enable bits read zero
    wr(16'h0100, 32'hFFFF_FFFF);
    rdChk("R4 enable readback", 16'h0100);
    chk("R4 literal", busRdata, 32'h0000_FFFF);
    wr(16'h0100, 32'h0);

    // R8 unmapped and misaligned accesses
    wr(16'h9000, 32'hDEAD_BEEF);
    rdChk("R8 window past last mailbox", 16'h9000);
    wr(16'h4002, 32'h8765_4321);
    rdChk("R8 misaligned write ignored", 16'h4000);
    wr(16'h0200, 32'hFFFF_FFFF);
    rdChk("R8 unmapped common read", 16'h0200);
    rdChk("R8 status unchanged", 16'h0304);
    wr(16'h100C, 32'h1);
    rdChk("R8 unused mailbox offset", 16'h100C);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 2) wr(randAddr(), randData());
      else rdChk("R1 R4 R6 R8 random read", randAddr());
      irqChk("R5 random irq");
    end
    for (int k = 0; k < NM; k++) rdChk("R1 final mailbox", 16'((k + 1) << 12));
    rdChk("R3 final status", 16'h0304);

    finishRun();
  end

endmodule